// File: doc/BRIEF.md
# Power-Aware Event Time Stamp Counter

This block keeps a 64-bit free-running event clock for a processor core. Every cycle it sees three strobes (core-clock tick, bus-clock tick, halt) and two power requests (stop-clock and deep sleep). It picks one of two increment modes when it leaves reset. In core-tick mode the count rises by one on every core-clock strobe, so its rate follows the core-to-bus ratio. In fixed-rate mode it adds a configured 6-bit ratio on every bus-clock strobe, which gives ticks of equal length whatever the core frequency.

A small power-state machine tracks four states: PS_RUN, PS_HALT, PS_STOPCLK and PS_SLEEP. Deep sleep has the highest priority, then stop-clock, then halt. The transitions are RUN/HALT/STOPCLK to SLEEP when a sleep request is seen, any non-sleep state to STOPCLK when stop-clock is requested without sleep, to HALT when only halt is set, and back to RUN when all three are clear. SLEEP exits to the highest-priority remaining request once the sleep request drops. The count advances in every state except PS_SLEEP, where it holds its value.

Software can load the full 64-bit value. A read request returns a snapshot one cycle later. When the access guard is set and the requester is unprivileged, the read returns zero and raises a fault pulse instead.

Top module: `evt_stamp_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count is zero and rd_valid, rd_fault and wrap_pulse are low.
- R2: In core-tick mode (mode_sel = 0) the count rises by exactly one at each clock edge where core_tick is 1, and bus_tick has no effect.
- R3: In fixed-rate mode (mode_sel = 1) the count rises by the captured ratio at each edge where bus_tick is 1, and core_tick has no effect.
- R4: halt and stop_req never change how the count advances.
- R5: The power state is registered. A sleep_req seen at one edge freezes the count from the next edge on. The value is held, not cleared, and counting resumes at the second edge after sleep_req falls.
- R6: mode_sel, ratio_cfg and rd_guard are captured only while rst_n is low. Later changes have no effect until the next reset.
- R7: A rd_req at one edge gives rd_valid = 1 in the following cycle, with rd_data equal to the count as it stood in the request cycle.
- R8: rd_guard carries bit 2 of the core control register. When the captured guard is 1 and user_mode is 1, a read returns zero with rd_fault high for that one cycle. Otherwise rd_fault stays low.
- R9: wr_en loads wr_data into the full count and takes priority over any increment in the same cycle.
- R10: An increment that carries out of bit 63 wraps the count modulo 2^64 without saturating. wrap_pulse is high for exactly the cycle in which the wrapped value is held. A write never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| core_tick | input | 1 | Core-clock strobe |
| bus_tick | input | 1 | Bus-clock strobe |
| halt | input | 1 | Core halted |
| stop_req | input | 1 | Stop-clock request |
| sleep_req | input | 1 | Deep-sleep request |
| mode_sel | input | 1 | 0 core-tick mode, 1 fixed-rate mode |
| ratio_cfg | input | 6 | Per-bus-tick step in fixed-rate mode |
| rd_guard | input | 1 | Bit 2 of the control register: restrict reads |
| user_mode | input | 1 | 1 marks an unprivileged requester |
| wr_en | input | 1 | Load request |
| wr_data | input | 64 | Value to load |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| rd_fault | output | 1 | Denied read pulse |
| wrap_pulse | output | 1 | Count wrapped past all-ones |

## Verification
The hardest situation to reach is a carry out of bit 63. Counting there from reset would take far too long. The stimulus therefore loads values just below all-ones through the write port, in the directed wrap case and in a share of the random writes. The fixed-rate ratio then steps across the boundary and lands on small non-zero values. Sleep requests are toggled in bursts so that entries and exits fall on cycles that also carry ticks, writes and reads. This exercises the one-cycle lag of the registered power state.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_HALT    = 2'd1,
        PS_STOPCLK = 2'd2,
        PS_SLEEP   = 2'd3
    } pwr_state_e;

    typedef enum logic {
        MODE_CORE  = 1'b0,
        MODE_CONST = 1'b1
    } inc_mode_e;

endpackage

// File: rtl/evt_stamp_ctl.sv
module evt_stamp_ctl
    import evt_stamp_pkg::*;
#(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt,
    input  logic               stop_req,
    input  logic               sleep_req,
    input  logic               mode_in,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               guard_in,
    output inc_mode_e          mode_q,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               guard_q,
    output logic               count_en
);

    pwr_state_e state_q, state_d;

    // next-state logic, priority sleep > stop-clock > halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (sleep_req)     state_d = PS_SLEEP;
                else if (stop_req) state_d = PS_STOPCLK;
                else if (halt)     state_d = PS_HALT;
            end
            PS_HALT: begin
                if (sleep_req)     state_d = PS_SLEEP;
                else if (stop_req) state_d = PS_STOPCLK;
                else if (!halt)    state_d = PS_RUN;
            end
            PS_STOPCLK: begin
                if (sleep_req)     state_d = PS_SLEEP;
                else if (!stop_req) state_d = halt ? PS_HALT : PS_RUN;
            end
            PS_SLEEP: begin
                if (!sleep_req) begin
                    if (stop_req)  state_d = PS_STOPCLK;
                    else if (halt) state_d = PS_HALT;
                    else           state_d = PS_RUN;
                end
            end
            default: state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // outputs: counting continues in every state but deep sleep
    always_comb begin
        count_en = 1'b1;
        unique case (state_q)
            PS_RUN, PS_HALT, PS_STOPCLK: count_en = 1'b1;
            PS_SLEEP:                    count_en = 1'b0;
            default:                     count_en = 1'b1;
        endcase
    end

    // configuration follows the inputs only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= inc_mode_e'(mode_in);
            ratio_q <= ratio_in;
            guard_q <= guard_in;
        end
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_q) && $stable(ratio_q) && $stable(guard_q)));

    // R5
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sleep_req)) |-> !count_en);

endmodule

// File: rtl/evt_stamp_accum.sv
module evt_stamp_accum
    import evt_stamp_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_en,
    input  inc_mode_e          mode,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               core_tick,
    input  logic               bus_tick,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               wrap_q
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] step;
    logic [CNT_W:0]   sum;

    always_comb begin
        step = '0;
        if (mode == MODE_CONST) begin
            if (bus_tick) step = {{(CNT_W-RATIO_W){1'b0}}, ratio};
        end else begin
            if (core_tick) step = ONE;
        end
        sum = {1'b0, cnt_q} + {1'b0, step};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (wr_en) begin
                cnt_q <= wr_data;
            end else if (count_en) begin
                cnt_q  <= sum[CNT_W-1:0];
                wrap_q <= sum[CNT_W];
            end
        end
    end

    // R9
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

    // R5
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !wr_en) |=> $stable(cnt_q));

    // R10
    wrap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (cnt_q < $past(cnt_q)));

    // R2
    core_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !wr_en && mode == MODE_CORE && core_tick && !(&cnt_q))
        |=> (cnt_q == $past(cnt_q) + ONE));

endmodule

// File: rtl/evt_stamp_rdport.sv
module evt_stamp_rdport #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             guard,
    input  logic             user_mode,
    input  logic             rd_req,
    input  logic [CNT_W-1:0] cnt,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_fault
);

    logic deny;
    assign deny = guard & user_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_fault <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            rd_fault <= rd_req & deny;
            rd_data  <= (rd_req && !deny) ? cnt : '0;
        end
    end

    // R8
    deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_valid && rd_data == '0));

    // R7
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top
    import evt_stamp_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_tick,
    input  logic               bus_tick,
    input  logic               halt,
    input  logic               stop_req,
    input  logic               sleep_req,
    input  logic               mode_sel,
    input  logic [RATIO_W-1:0] ratio_cfg,
    input  logic               rd_guard,
    input  logic               user_mode,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               rd_req,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rd_fault,
    output logic               wrap_pulse
);

    inc_mode_e          mode_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               guard_q;
    logic               count_en;
    logic [CNT_W-1:0]   cnt;

    evt_stamp_ctl #(.RATIO_W(RATIO_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .stop_req (stop_req),
        .sleep_req(sleep_req),
        .mode_in  (mode_sel),
        .ratio_in (ratio_cfg),
        .guard_in (rd_guard),
        .mode_q   (mode_q),
        .ratio_q  (ratio_q),
        .guard_q  (guard_q),
        .count_en (count_en)
    );

    evt_stamp_accum #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .mode     (mode_q),
        .ratio    (ratio_q),
        .core_tick(core_tick),
        .bus_tick (bus_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cnt_q    (cnt),
        .wrap_q   (wrap_pulse)
    );

    evt_stamp_rdport #(.CNT_W(CNT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard    (guard_q),
        .user_mode(user_mode),
        .rd_req   (rd_req),
        .cnt      (cnt),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_fault (rd_fault)
    );

endmodule

// File: tb/test_evt_stamp_top.sv
`timescale 1ns/1ps
module test_evt_stamp_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_tick = 1'b0, bus_tick = 1'b0, halt = 1'b0, stop_req = 1'b0, sleep_req = 1'b0;
    logic        mode_sel = 1'b0;
    logic [5:0]  ratio_cfg = '0;
    logic        rd_guard = 1'b0, user_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid, rd_fault, wrap_pulse;
    logic [63:0] rd_data;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    chk_on   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    evt_stamp_top i_evt_stamp_top (
        .clk(clk), .rst_n(rst_n), .core_tick(core_tick), .bus_tick(bus_tick),
        .halt(halt), .stop_req(stop_req), .sleep_req(sleep_req),
        .mode_sel(mode_sel), .ratio_cfg(ratio_cfg), .rd_guard(rd_guard),
        .user_mode(user_mode), .wr_en(wr_en), .wr_data(wr_data), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault),
        .wrap_pulse(wrap_pulse)
    );

    // ---------------- reference model ----------------
    logic        m_mode, m_guard, m_sleep;
    logic [5:0]  m_ratio;
    logic [63:0] m_cnt, m_rdd;
    logic        m_rdv, m_flt, m_wrap;

    function automatic logic [64:0] next_sum(input logic mode, input logic [5:0] ratio,
                                             input logic ct, input logic bt,
                                             input logic [63:0] c);
        logic [63:0] s;
        s = mode ? (bt ? {58'd0, ratio} : 64'd0) : (ct ? 64'd1 : 64'd0);
        return {1'b0, c} + {1'b0, s};
    endfunction

    always @(posedge clk) begin
        logic [64:0] ns;
        ns = next_sum(m_mode, m_ratio, core_tick, bus_tick, m_cnt);
        if (!rst_n) begin
            m_mode <= mode_sel; m_ratio <= ratio_cfg; m_guard <= rd_guard;
            m_sleep <= 1'b0; m_cnt <= '0; m_wrap <= 1'b0;
            m_rdv <= 1'b0; m_rdd <= '0; m_flt <= 1'b0;
        end else begin
            m_sleep <= sleep_req;
            m_wrap  <= 1'b0;
            if (wr_en) m_cnt <= wr_data;
            else if (!m_sleep) begin
                m_cnt  <= ns[63:0];
                m_wrap <= ns[64];
            end
            m_rdv <= rd_req;
            m_flt <= rd_req & m_guard & user_mode;
            m_rdd <= (m_guard & user_mode) ? 64'd0 : m_cnt;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("R7", {63'd0, rd_valid}, {63'd0, m_rdv});
            if (m_rdv) check(cur_req, rd_data, m_rdd);
            check("R8", {63'd0, rd_fault}, {63'd0, m_flt});
            check("R10", {63'd0, wrap_pulse}, {63'd0, m_wrap});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input logic ct, input logic bt, input logic h, input logic st,
                       input logic sl, input logic we, input logic [63:0] wd,
                       input logic rq, input logic um);
        @(negedge clk);
        core_tick = ct; bus_tick = bt; halt = h; stop_req = st; sleep_req = sl;
        wr_en = we; wr_data = wd; rd_req = rq; user_mode = um;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 64'd0, 0, 0);
    endtask

    task automatic read_chk(input string req, input logic um, input logic [63:0] exp);
        cyc(0, 0, 0, 0, 0, 0, 64'd0, 1, um);
        idle();
        check(req, rd_data, exp);
    endtask

    task automatic do_reset(input logic md, input logic [5:0] rt, input logic gd);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = md; ratio_cfg = rt; rd_guard = gd;
        core_tick = 0; bus_tick = 0; halt = 0; stop_req = 0; sleep_req = 0;
        wr_en = 0; rd_req = 0; user_mode = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check("R1", {61'd0, rd_valid, rd_fault, wrap_pulse}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic random_run(input int n);
        logic sl = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic we;
            logic [63:0] wd;
            if ($urandom % 16 == 0) sl = ~sl;
            we = ($urandom % 64 == 0);
            wd = ($urandom % 2) ? {32'hFFFF_FFFF, 26'h3FF_FFFF, 6'($urandom)}
                                : {$urandom, $urandom};
            cyc($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, sl,
                we, wd, ($urandom % 3 == 0), $urandom % 2);
        end
        idle(); idle();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240);
        chk_on = 1'b1;

        // core-tick mode, open reads
        do_reset(1'b0, 6'd9, 1'b0);
        cur_req = "R1";
        read_chk("R1", 1'b0, 64'd0);
        // R2 and R4: ten core ticks with halt/stop toggling, bus ticks ignored
        cur_req = "R2";
        for (int i = 0; i < 10; i++) cyc(1, 1, i[0], i[1], 0, 0, 64'd0, 0, 0);
        read_chk("R4", 1'b0, 64'd10);
        // R9: write wins over a same-cycle tick
        cyc(1, 0, 0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, 0, 0);
        read_chk("R9", 1'b0, 64'h1234_5678_9ABC_DEF0);
        // R5: one tick slips in before the freeze, value held while asleep
        cyc(0, 0, 0, 0, 0, 1, 64'd100, 0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 1, 0, 64'd0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 64'd0, 0, 0);
        read_chk("R5", 1'b0, 64'd101);
        cur_req = "R2";
        random_run(3000);

        // fixed-rate mode, ratio 5
        do_reset(1'b1, 6'd5, 1'b0);
        cur_req = "R3";
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 64'd0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 64'd0, 0, 0);
        read_chk("R3", 1'b0, 64'd20);
        // R10: wrap from just below all-ones
        cyc(0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 64'd0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 64'd0, 1, 0);
        check("R10", {63'd0, wrap_pulse}, 64'd1);
        idle();
        check("R10", rd_data, 64'd3);
        check("R10", {63'd0, wrap_pulse}, 64'd0);
        random_run(3000);

        // R6: configuration changed after reset release is ignored
        do_reset(1'b1, 6'd3, 1'b0);
        cur_req = "R6";
        mode_sel = 1'b0; ratio_cfg = 6'd60; rd_guard = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 64'd0, 0, 0);
        read_chk("R6", 1'b1, 64'd12);
        check("R6", {63'd0, rd_fault}, 64'd0);

        // R8: guarded reads
        do_reset(1'b0, 6'd0, 1'b1);
        cur_req = "R8";
        cyc(0, 0, 0, 0, 0, 1, 64'd777, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 64'd0, 1, 1);
        idle();
        check("R8", rd_data, 64'd0);
        check("R8", {63'd0, rd_fault}, 64'd1);
        idle();
        check("R8", {63'd0, rd_fault}, 64'd0);
        read_chk("R8", 1'b0, 64'd777);
        cur_req = "R7";
        random_run(3000);

        finish_run();
    end

endmodule